// File: doc/BRIEF.md
# Minimum Idle Delay Checker

This block is a synthesizable runtime monitor that sits on one clock and watches a `valid` strobe and an `idle` indication. Each time `valid` drops, the monitor opens a guard window. Its length, in cycles, is taken from a programmable gap input at that moment. If `idle` asserts while the window is still running, the monitor reports a violation. If `idle` asserts after the window has elapsed, the window closes quietly. If `valid` comes back first, the check is abandoned. A gap value of zero imposes no restriction.

Violations appear as a one-cycle pulse, a flag that stays set until reset, and a saturating count. A window-open output shows whether a check is currently pending. The gap input may be rewritten at any time. A change only takes effect at the next drop of `valid`.

Top module: `idle_gap_monitor`

## Requirements
- R1: A drop of `valid` (sampled high on one clock edge, low on the next) with `idle_i` low on that same edge sets `win_open_o` high after that edge. `win_open_o` stays high while `valid_i` and `idle_i` both stay low.
- R2: Window cycle 1 is the edge on which `valid_i` is first sampled low, and each later edge adds one. If `idle_i` is sampled high on a window cycle whose index is less than or equal to the latched gap, `err_pulse_o` is high for exactly the one clock after that edge.
- R3: A gap value of zero never produces a violation. This includes `idle_i` high on the same edge that `valid` drops.
- R4: The gap is captured from `min_gap_i` at the drop of `valid`. Changes to `min_gap_i` during an open window do not affect that window.
- R5: `idle_i` sampled high on a window cycle whose index is above the latched gap closes the window (`win_open_o` low after that edge) with no error.
- R6: `valid_i` sampled high while a window is open cancels it with no error. This holds even when `idle_i` is high on the same edge, because `valid` takes priority.
- R7: `err_sticky_o` is set on the same edge that `err_pulse_o` rises, and stays set until reset.
- R8: `err_count_o` increments by one per violation, on the same edge as `err_pulse_o`, and saturates at 255.
- R9: While `rst_n` is sampled low, all outputs clear and the window state is discarded. A `valid_i` that is low on the first edge after reset does not open a window.
- R10: A violation closes the window at once, so one early `idle` is reported only once.
- R11: After a cancellation, the next drop of `valid` opens a fresh window with the gap value present at that new drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Monitored valid strobe |
| idle_i | input | 1 | Monitored idle indication |
| min_gap_i | input | DLY_W (8) | Minimum number of cycles `idle` must stay low after `valid` drops |
| err_pulse_o | output | 1 | One-clock violation pulse |
| err_sticky_o | output | 1 | Violation flag held until reset |
| win_open_o | output | 1 | A guard window is pending |
| err_count_o | output | CNT_W (8) | Saturating violation count |

## Verification
Several properties are asserted on every cycle:
- the sticky flag never drops;
- the count never decreases;
- a pulse never repeats on consecutive clocks;
- a zero gap never produces a violation at the drop;
- a reported violation leaves the window closed;
- a returning `valid` always closes the window;
- the latched gap holds steady while a window waits.

Other behaviour depends on the sequence of stimulus over several cycles: whether an idle at a given window index counts as early, that gap rewrites mid-window are ignored, that a cancelled window is followed by a fresh one using the new gap, and that the counter saturates. Only the bench scenarios can show these, by comparison against its cycle model.

// File: rtl/idle_gap_pkg.sv
// Shared types for the minimum idle delay monitor.
// Assumes: nothing beyond a single clock domain.
package idle_gap_pkg;
    typedef enum logic {
        WIN_REST  = 1'b0,
        WIN_GUARD = 1'b1
    } win_state_e;
endpackage

// File: rtl/idle_gap_edge.sv
// Registers the monitored valid strobe and flags its falling edge.
// Assumes: valid_i is synchronous to clk; the register resets low so a
// valid that is low straight after reset is not taken as a drop.
module idle_gap_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic valid_i,
    output logic fall_o
);
    logic valid_q;

    // hold last sampled valid for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= valid_i;
    end

    // drop: high on previous edge, low on this one
    assign fall_o = valid_q & ~valid_i;
endmodule

// File: rtl/idle_gap_window.sv
// Tracks one guard window: latches the gap at the drop of valid, counts
// window cycles and judges an idle assertion as early or allowed.
// Assumes: at most one window at a time; a drop cannot occur while a window
// is open, since valid is low throughout.
module idle_gap_window
    import idle_gap_pkg::*;
#(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_i,
    input  logic             valid_i,
    input  logic             idle_i,
    input  logic [DLY_W-1:0] gap_i,
    output logic             armed_o,
    output logic             viol_o
);
    localparam int AGE_W = DLY_W + 1;
    localparam logic [AGE_W-1:0] AGE_MAX = {AGE_W{1'b1}};

    win_state_e       state, state_n;
    logic [AGE_W-1:0] age, age_n, idx;
    logic [DLY_W-1:0] lat, lat_n;

    // next window index, saturating so long waits never wrap
    assign idx = (age == AGE_MAX) ? age : age + 1'b1;

    // window next-state and verdict for the current sample
    always_comb begin
        state_n = state;
        age_n   = age;
        lat_n   = lat;
        viol_o  = 1'b0;
        if (fall_i) begin
            lat_n = gap_i;
            age_n = AGE_W'(1);
            if (idle_i) begin
                viol_o  = (gap_i != '0);
                state_n = WIN_REST;
            end else begin
                state_n = WIN_GUARD;
            end
        end else if (state == WIN_GUARD) begin
            if (valid_i) begin
                state_n = WIN_REST;
            end else begin
                age_n = idx;
                if (idle_i) begin
                    viol_o  = (idx <= {1'b0, lat});
                    state_n = WIN_REST;
                end
            end
        end
    end

    // window state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WIN_REST;
            age   <= '0;
            lat   <= '0;
        end else begin
            state <= state_n;
            age   <= age_n;
            lat   <= lat_n;
        end
    end

    assign armed_o = (state == WIN_GUARD);

    // R6
    cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_o && valid_i) |=> !armed_o);

    // R3
    zero_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_i && gap_i == '0) |-> !viol_o);

    // R4
    lat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_o && !valid_i && !idle_i) |=> (armed_o && $stable(lat)));
endmodule

// File: rtl/idle_gap_errlog.sv
// Turns a per-sample violation verdict into a registered pulse, a sticky
// flag and a saturating count.
// Assumes: viol_i is a single-cycle verdict from the window tracker.
module idle_gap_errlog #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             viol_i,
    output logic             pulse_o,
    output logic             sticky_o,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // register the violation outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_o  <= 1'b0;
            sticky_o <= 1'b0;
            count_o  <= '0;
        end else begin
            pulse_o <= viol_i;
            if (viol_i) begin
                sticky_o <= 1'b1;
                if (count_o != CNT_MAX) count_o <= count_o + 1'b1;
            end
        end
    end

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sticky_o |=> sticky_o);

    // R8
    count_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count_o >= $past(count_o)));

    // R2
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);
endmodule

// File: rtl/idle_gap_monitor.sv
// Top of the minimum idle delay monitor: a drop of valid opens a guard
// window of min_gap_i cycles; idle inside it is a violation, valid coming
// back cancels it.
// Assumes: all inputs are synchronous to clk; min_gap_i may change freely.
module idle_gap_monitor #(
    parameter int DLY_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic             idle_i,
    input  logic [DLY_W-1:0] min_gap_i,
    output logic             err_pulse_o,
    output logic             err_sticky_o,
    output logic             win_open_o,
    output logic [CNT_W-1:0] err_count_o
);
    logic fall;
    logic viol;

    // drop detector
    idle_gap_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (valid_i),
        .fall_o  (fall)
    );

    // guard window tracker
    idle_gap_window #(.DLY_W(DLY_W)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .fall_i  (fall),
        .valid_i (valid_i),
        .idle_i  (idle_i),
        .gap_i   (min_gap_i),
        .armed_o (win_open_o),
        .viol_o  (viol)
    );

    // violation reporting
    idle_gap_errlog #(.CNT_W(CNT_W)) u_log (
        .clk      (clk),
        .rst_n    (rst_n),
        .viol_i   (viol),
        .pulse_o  (err_pulse_o),
        .sticky_o (err_sticky_o),
        .count_o  (err_count_o)
    );

    // R10
    close_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_pulse_o |-> !win_open_o);
endmodule

// File: tb/sim_idle_gap_monitor.sv
// Bench: cycle model plus directed corners and seeded random stimulus.
module sim_idle_gap_monitor;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       valid_i = 1'b0;
    logic       idle_i = 1'b0;
    logic [7:0] min_gap_i = '0;
    logic       err_pulse_o, err_sticky_o, win_open_o;
    logic [7:0] err_count_o;

    int n_chk = 0;
    int n_bad = 0;

    // model state
    bit m_vprev, m_open, m_pulse, m_sticky;
    int m_age, m_lat, m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    idle_gap_monitor u0 (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .idle_i(idle_i),
        .min_gap_i(min_gap_i), .err_pulse_o(err_pulse_o),
        .err_sticky_o(err_sticky_o), .win_open_o(win_open_o),
        .err_count_o(err_count_o)
    );

    function automatic bit early(input int age, input int lat);
        return age <= lat;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model(input bit r, input bit v, input bit i, input int d);
        bit viol = 1'b0;
        if (!r) begin
            m_vprev = 0; m_open = 0; m_pulse = 0; m_sticky = 0;
            m_age = 0; m_lat = 0; m_cnt = 0;
            return;
        end
        if (m_vprev && !v) begin
            m_lat = d; m_age = 1;
            if (i) begin viol = early(1, d); m_open = 0; end
            else m_open = 1;
        end else if (m_open) begin
            if (v) m_open = 0;
            else begin
                m_age++;
                if (i) begin viol = early(m_age, m_lat); m_open = 0; end
            end
        end
        m_vprev = v;
        m_pulse = viol;
        if (viol) begin
            m_sticky = 1;
            if (m_cnt < 255) m_cnt++;
        end
    endtask

    // one clock: drive at negedge, compare just after the posedge
    task automatic step(input bit v, input bit i, input int d);
        @(negedge clk);
        valid_i = v; idle_i = i; min_gap_i = 8'(d);
        @(posedge clk);
        model(rst_n, v, i, d);
        #1;
        chk("R2 pulse", int'(err_pulse_o), int'(m_pulse));
        chk("R7 sticky", int'(err_sticky_o), int'(m_sticky));
        chk("R8 count", int'(err_count_o), m_cnt);
        chk("R1 window", int'(win_open_o), int'(m_open));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(0, 0, 0);
        step(0, 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R9: cleared, and low valid after reset is no drop
        step(0, 1, 3);
        chk("R9 reset", int'({err_pulse_o, err_sticky_o, win_open_o}), 0);
        chk("R9 count", int'(err_count_o), 0);

        // R1 + R2: gap 3, idle at window cycle 2
        step(1, 0, 3);
        step(0, 0, 3);
        chk("R1 open", int'(win_open_o), 1);
        step(0, 1, 3);
        chk("R2 pulse", int'(err_pulse_o), 1);
        chk("R10 closed", int'(win_open_o), 0);
        step(0, 1, 3);
        chk("R10 once", int'(err_pulse_o), 0);
        chk("R8 one", int'(err_count_o), 1);

        // R5: gap 2, idle at cycle 3 is allowed
        step(1, 0, 2);
        step(0, 0, 2);
        step(0, 0, 2);
        step(0, 1, 2);
        chk("R5 no err", int'(err_pulse_o), 0);
        chk("R5 closed", int'(win_open_o), 0);

        // R2 boundary: gap 2, idle exactly at cycle 2
        step(1, 0, 2);
        step(0, 0, 2);
        step(0, 1, 2);
        chk("R2 boundary", int'(err_pulse_o), 1);

        // R3: gap 0, idle on the drop edge
        step(1, 0, 0);
        step(0, 1, 0);
        chk("R3 zero gap", int'(err_pulse_o), 0);

        // R4: gap 4 latched, input rewritten to 0 mid-window
        step(1, 0, 4);
        step(0, 0, 4);
        step(0, 0, 0);
        step(0, 1, 0);
        chk("R4 latched", int'(err_pulse_o), 1);

        // R6: valid back with idle high the same edge cancels
        step(1, 0, 5);
        step(0, 0, 5);
        step(1, 1, 5);
        chk("R6 cancel", int'(err_pulse_o), 0);
        chk("R6 closed", int'(win_open_o), 0);

        // R11: fresh window uses new gap 1, idle at cycle 2 allowed
        step(0, 0, 1);
        step(0, 1, 1);
        chk("R11 fresh", int'(err_pulse_o), 0);
        chk("R7 held", int'(err_sticky_o), 1);

        // R8: saturation
        for (int k = 0; k < 260; k++) begin
            step(1, 0, 3);
            step(0, 1, 3);
        end
        chk("R8 saturate", int'(err_count_o), 255);

        // R9: reset mid-run
        step(1, 0, 3);
        step(0, 0, 3);
        do_reset();
        step(0, 1, 3);
        chk("R9 mid reset", int'({err_sticky_o, win_open_o}), 0);
        chk("R9 mid count", int'(err_count_o), 0);

        // random stimulus
        for (int k = 0; k < 4000; k++) begin
            if ($urandom % 600 == 0) do_reset();
            step(($urandom % 3) != 0, ($urandom % 4) == 0, int'($urandom % 6));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule